// File: doc/BRIEF.md
# Dual-Task Video Event Sequencer

This block hands video processing back and forth between two task setups, A and B. Each setup carries its own enable, a two-bit handover trigger code and a repeat flag. The sequencer watches a task-done pulse from the processing pipeline, a vertical-sync pulse and the current field parity. From these it decides when the next task may begin. It then drives a task-select output, which picks the active setup, and a one-cycle task-start strobe.

When a task finishes, the sequencer enters a waiting phase. The trigger code that applies is the one belonging to the task that just finished. The code chooses one of four handover points: at once, at the next vertical sync, at the next vertical sync of an even field, or at the next vertical sync of an odd field. A task whose repeat flag is set runs a second time before control passes to the other task. A lone enabled task restarts at every trigger. With no task enabled, the sequencer waits and issues nothing.

Top module: `evseq_dual_task`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `task_sel` is 0 (task A) and `task_start` is 0. The first start after reset selects task A when A is enabled. It uses A's trigger code.
- R2: Trigger code 2'b00 is immediate. The strobe rises two clock edges after the edge that samples `task_done`.
- R3: Trigger code 2'b01 gives a start on the edge after the first edge following task completion that samples `vsync` high. A `vsync` sampled on the same edge as `task_done` does not count.
- R4: Trigger code 2'b10 starts only on a sampled `vsync` with `field_id` = 0. A `vsync` with `field_id` = 1 gives no start.
- R5: Trigger code 2'b11 starts only on a sampled `vsync` with `field_id` = 1. A `vsync` with `field_id` = 0 gives no start.
- R6: With both tasks enabled and repeat flags at 0, starts alternate A, B, A, ….
- R7: A task whose repeat flag reads 1 at its first start runs twice in a row before the other task starts. The repeat count clears at each handover.
- R8: With only one task enabled, that task is restarted at every trigger.
- R9: With neither task enabled, no start is issued. Once a task is enabled, it starts at the next trigger condition.
- R10: `task_start` is high for exactly one cycle. A `task_done` received while waiting is ignored, so each completion gives at most one start.
- R11: `task_sel` changes only in the cycle where `task_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_enable | input | 1 | Task A enabled |
| a_trig | input | 2 | Task A handover trigger code |
| a_rpt | input | 1 | Task A repeat-once flag |
| b_enable | input | 1 | Task B enabled |
| b_trig | input | 2 | Task B handover trigger code |
| b_rpt | input | 1 | Task B repeat-once flag |
| task_done | input | 1 | Pulse: active task finished |
| vsync | input | 1 | Vertical-sync pulse |
| field_id | input | 1 | Current field parity |
| task_sel | output | 1 | Active setup, 0 = A, 1 = B |
| task_start | output | 1 | One-cycle start strobe |

## Verification
The handover is tried under each trigger code in turn. For the sync-based codes, a sync of the wrong parity, or a sync that coincides with completion, comes before the valid one, so an early or wrong-field start is caught. The bench then runs the task sequence with repeat flags set, with one task enabled and with none, and compares the order of starts against a queue. This shows apart alternation, repetition, restart of a single task and silence. A stray extra `task_done` while waiting checks that a single completion cannot produce two starts.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
    localparam int NUM_TASKS = 2;
    localparam int CODE_W    = 2;

    typedef enum logic {
        TASK_A = 1'b0,
        TASK_B = 1'b1
    } task_id_e;

    typedef enum logic [CODE_W-1:0] {
        TRG_NOW    = 2'b00,
        TRG_VSYNC  = 2'b01,
        TRG_FIELD0 = 2'b10,
        TRG_FIELD1 = 2'b11
    } trig_code_e;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e   phase;
        task_id_e cur;
        task_id_e tgt;
        logic     is_rep;
        logic     rep_left;
        logic     start;
    } seq_state_t;

    function automatic task_id_e peer(input task_id_e t);
        return task_id_e'(~t);
    endfunction
endpackage

// File: rtl/evseq_trig_eval.sv
module evseq_trig_eval
    import evseq_pkg::*;
(
    input  trig_code_e code,
    input  logic       vsync,
    input  logic       field_id,
    output logic       fire
);
    always_comb begin
        unique case (code)
            TRG_NOW:    fire = 1'b1;
            TRG_VSYNC:  fire = vsync;
            TRG_FIELD0: fire = vsync & ~field_id;
            TRG_FIELD1: fire = vsync & field_id;
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/evseq_task_pick.sv
module evseq_task_pick
    import evseq_pkg::*;
(
    input  logic [NUM_TASKS-1:0] en,
    input  task_id_e             pref,
    output logic                 ok,
    output task_id_e             pick
);
    always_comb begin
        ok   = 1'b0;
        pick = pref;
        if (en[pref]) begin
            ok   = 1'b1;
            pick = pref;
        end else if (en[peer(pref)]) begin
            ok   = 1'b1;
            pick = peer(pref);
        end
    end
endmodule

// File: rtl/evseq_dual_task.sv
module evseq_dual_task
    import evseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a_enable,
    input  logic [1:0] a_trig,
    input  logic       a_rpt,
    input  logic       b_enable,
    input  logic [1:0] b_trig,
    input  logic       b_rpt,
    input  logic       task_done,
    input  logic       vsync,
    input  logic       field_id,
    output logic       task_sel,
    output logic       task_start
);
    localparam seq_state_t RST_STATE = '{
        phase:    PH_WAIT,
        cur:      TASK_A,
        tgt:      TASK_A,
        is_rep:   1'b0,
        rep_left: 1'b0,
        start:    1'b0
    };

    // per-task configuration gathered into indexable vectors
    logic [NUM_TASKS-1:0] en_vec;
    logic [NUM_TASKS-1:0] rpt_vec;
    logic [CODE_W-1:0]    trig_vec [NUM_TASKS];

    for (genvar gi = 0; gi < NUM_TASKS; gi++) begin : g_cfg
        if (gi == 0) begin : g_a
            assign en_vec[gi]   = a_enable;
            assign rpt_vec[gi]  = a_rpt;
            assign trig_vec[gi] = a_trig;
        end else begin : g_b
            assign en_vec[gi]   = b_enable;
            assign rpt_vec[gi]  = b_rpt;
            assign trig_vec[gi] = b_trig;
        end
    end

    seq_state_t st_q, st_d;

    // trigger code of the task that finished last governs the wait
    trig_code_e cur_code;
    logic       fire;
    logic       pick_ok;
    task_id_e   pick;

    assign cur_code = trig_code_e'(trig_vec[st_q.cur]);

    evseq_trig_eval u_trig (
        .code     (cur_code),
        .vsync    (vsync),
        .field_id (field_id),
        .fire     (fire)
    );

    evseq_task_pick u_pick (
        .en   (en_vec),
        .pref (st_q.tgt),
        .ok   (pick_ok),
        .pick (pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        unique case (st_q.phase)
            PH_RUN: begin
                if (task_done) begin
                    st_d.phase = PH_WAIT;
                    if (st_q.rep_left) begin
                        st_d.tgt    = st_q.cur;
                        st_d.is_rep = 1'b1;
                    end else begin
                        st_d.is_rep = 1'b0;
                        st_d.tgt    = en_vec[peer(st_q.cur)] ? peer(st_q.cur) : st_q.cur;
                    end
                end
            end
            PH_WAIT: begin
                if (fire && pick_ok) begin
                    st_d.phase    = PH_RUN;
                    st_d.start    = 1'b1;
                    st_d.cur      = pick;
                    st_d.rep_left = (st_q.is_rep && pick == st_q.tgt) ? 1'b0 : rpt_vec[pick];
                end
            end
            default: st_d = RST_STATE;
        endcase
        if (rst) begin
            st_d = RST_STATE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign task_sel   = st_q.cur;
    assign task_start = st_q.start;

    // history-valid flag for assertions that look one cycle back
    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= ~rst;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        task_start |=> !task_start); // R10

    AST_SEL_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !task_start) |-> $stable(task_sel)); // R11

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && task_start) |-> ($past(a_enable) || $past(b_enable))); // R9

    AST_SYNC_GATED: assert property (@(posedge clk) disable iff (rst)
        (armed_q && task_start && $past(cur_code) != TRG_NOW) |-> $past(vsync)); // R3

    AST_EVEN_FIELD: assert property (@(posedge clk) disable iff (rst)
        (armed_q && task_start && $past(cur_code) == TRG_FIELD0) |-> !$past(field_id)); // R4

    AST_ODD_FIELD: assert property (@(posedge clk) disable iff (rst)
        (armed_q && task_start && $past(cur_code) == TRG_FIELD1) |-> $past(field_id)); // R5
endmodule

// File: tb/tb_evseq_dual_task.sv
module tb_evseq_dual_task;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_enable = 1'b0, b_enable = 1'b0;
    logic [1:0] a_trig = 2'b00, b_trig = 2'b00;
    logic       a_rpt = 1'b0, b_rpt = 1'b0;
    logic       task_done = 1'b0, vsync = 1'b0, field_id = 1'b0;
    logic       task_sel, task_start;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    evseq_dual_task dut (
        .clk(clk), .rst(rst),
        .a_enable(a_enable), .a_trig(a_trig), .a_rpt(a_rpt),
        .b_enable(b_enable), .b_trig(b_trig), .b_rpt(b_rpt),
        .task_done(task_done), .vsync(vsync), .field_id(field_id),
        .task_sel(task_sel), .task_start(task_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one-cycle stimulus, returns at the negedge after the sampling edge
    task automatic pulse(input logic d, input logic v, input logic f);
        @(negedge clk);
        task_done = d; vsync = v; field_id = f;
        @(negedge clk);
        task_done = 1'b0; vsync = 1'b0; field_id = 1'b0;
    endtask

    task automatic expect_task(input int t);
        exp_q.push_back(t);
    endtask

    // monitor: compares each start against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && task_start) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected start", int'(task_sel), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(task_sel) == e, "R6 start order", int'(task_sel), e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL ALL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(task_sel == 1'b0 && task_start == 1'b0, "R1 reset state", int'({task_sel, task_start}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(task_sel == 1'b0 && task_start == 1'b0, "R1 after reset", int'({task_sel, task_start}), 0);
        repeat (4) @(negedge clk);
        check(task_start == 1'b0, "R9 idle without enable", int'(task_start), 0);

        // R1: first start is A
        expect_task(0);
        a_enable = 1'b1; b_enable = 1'b1;
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R1 first start A", int'({task_sel, task_start}), 1);

        // R2 immediate, R6 alternation
        expect_task(1);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b1, "R2 immediate handover to B", int'({task_sel, task_start}), 3);
        @(negedge clk);
        check(task_start == 1'b0, "R10 strobe width", int'(task_start), 0);
        expect_task(0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R6 back to A", int'({task_sel, task_start}), 1);

        // R3 vsync trigger, coincident vsync ignored
        a_trig = 2'b01;
        pulse(1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check(task_start == 1'b0, "R3 coincident vsync ignored", int'(task_start), 0);
        check(task_sel == 1'b0, "R11 sel held while waiting", int'(task_sel), 0);
        expect_task(1);
        pulse(1'b0, 1'b1, 1'b0);
        check(task_start == 1'b1 && task_sel == 1'b1, "R3 start on vsync", int'({task_sel, task_start}), 3);

        // R4 even field
        b_trig = 2'b10;
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b1);
        check(task_start == 1'b0, "R4 odd field ignored", int'(task_start), 0);
        expect_task(0);
        pulse(1'b0, 1'b1, 1'b0);
        check(task_start == 1'b1 && task_sel == 1'b0, "R4 start on even field", int'({task_sel, task_start}), 1);

        // R5 odd field
        a_trig = 2'b11;
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        check(task_start == 1'b0, "R5 even field ignored", int'(task_start), 0);
        expect_task(1);
        pulse(1'b0, 1'b1, 1'b1);
        check(task_start == 1'b1 && task_sel == 1'b1, "R5 start on odd field", int'({task_sel, task_start}), 3);

        // R7 repeat once
        a_trig = 2'b00; b_trig = 2'b00; a_rpt = 1'b1;
        expect_task(0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R7 first run of A", int'({task_sel, task_start}), 1);
        expect_task(0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R7 repeat run of A", int'({task_sel, task_start}), 1);
        expect_task(1);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b1, "R7 handover after repeat", int'({task_sel, task_start}), 3);

        // R8 single task
        a_rpt = 1'b0; b_enable = 1'b0;
        expect_task(0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R8 move to sole task A", int'({task_sel, task_start}), 1);
        expect_task(0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b0, "R8 restart A", int'({task_sel, task_start}), 1);

        // R9 nothing enabled, then enable B
        a_enable = 1'b0;
        pulse(1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(task_start == 1'b0 && task_sel == 1'b0, "R9 no start with none enabled", int'({task_sel, task_start}), 0);
        expect_task(1);
        b_enable = 1'b1;
        @(negedge clk);
        check(task_start == 1'b1 && task_sel == 1'b1, "R9 start once enabled", int'({task_sel, task_start}), 3);

        // R10 extra done while waiting
        b_trig = 2'b01;
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        check(task_start == 1'b0, "R10 no start before vsync", int'(task_start), 0);
        expect_task(1);
        pulse(1'b0, 1'b1, 1'b0);
        check(task_start == 1'b1 && task_sel == 1'b1, "R10 single start", int'({task_sel, task_start}), 3);
        @(negedge clk);
        check(task_start == 1'b0, "R10 strobe drops", int'(task_start), 0);
        pulse(1'b0, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all expected starts seen", exp_q.size(), 0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule